// File: doc/BRIEF.md
# Three-Phase Inverter Gate Guard

This block sits between a motor controller's six PWM commands and the six gate-enable signals of a three-phase bridge. Each phase has one command for the upper transistor and one for the lower. Both are active low. The block passes each command through to its gate. On the way it prevents the two transistors of a phase from conducting together, and it inserts a dead gap whenever a phase hands over from one leg to the other.

The block also applies protection, and the protection is not the same for both sides. A qualified short-circuit flag from the lower-rail current sense, or a lower-side supply under-voltage flag, switches off all three lower gates and starts a fault pulse of fixed length. The fault pulse is active low and idles high. An under-voltage flag on one upper-side supply switches off only that phase's upper gate and raises no fault. That gate stays off after the supply recovers until the controller issues a new on-command for it.

All inputs are synchronous logic levels. Each one passes through a two-flop synchronizer, and all outputs are registered.

Top module: `invgate_guard`

## Requirements
- R1: While reset is high and on the first cycle after it, all six gate outputs are 0 and `fault_n` is 1.
- R2: Command bits are active low (0 = on request, 1 = off request). When nothing blocks a command, the gate output follows a command change on the third rising edge after the change is presented.
- R3: If both commands of a phase request on at the same time, both gates of that phase are 0. Releasing one of the two commands lets the other leg turn on.
- R4: The two gates of a phase are never 1 together. A gate turns on only after both gates of its phase have been off for at least `DEAD_CYC` edges, and this count restarts every time either gate of the phase turns off.
- R5: A synchronized `sc_flag` that stays high for fewer than `SC_QUAL` consecutive cycles has no effect on the gates or on `fault_n`.
- R6: A qualified short circuit switches all lower gates off on the same edge that `fault_n` falls. The upper gates keep following their commands.
- R7: Each fault pulse holds `fault_n` low for exactly `FAULT_CYC` cycles.
- R8: A short-circuit trip or an under-voltage onset that arrives during a running fault pulse neither restarts nor extends that pulse.
- R9: While `fault_n` is 0, every lower gate is 0 whatever its command. When the pulse ends, lower legs that are still commanded on resume.
- R10: A rise of `uv_lo_flag` starts a fault pulse. The lower gates stay off for as long as the flag is high, even after the pulse has ended, and they follow their commands again once the flag clears.
- R11: `uv_hi_flag[p]` switches off only the upper gate of phase p and never drives `fault_n` low.
- R12: After `uv_hi_flag[p]` clears, the upper gate of phase p stays off. It turns on again only after its command goes from off to on; a command that stays at on does not turn it back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hi_n | input | NPH | Upper-leg commands, low = on |
| cmd_lo_n | input | NPH | Lower-leg commands, low = on |
| sc_flag | input | 1 | Short-circuit comparator flag from the lower-rail shunt |
| uv_lo_flag | input | 1 | Lower-side control supply under-voltage flag |
| uv_hi_flag | input | NPH | Per-phase upper-side supply under-voltage flags |
| gate_hi | output | NPH | Upper gate enables, registered |
| gate_lo | output | NPH | Lower gate enables, registered |
| fault_n | output | 1 | Fault pulse, active low, registered |

## Verification
The dead-gap and pulse-width properties assume two things: the gate outputs change only on clock edges, and reset is not raised in the middle of a fault pulse. Outside reset, the bench never pulses reset. The properties also take every flag to be a clean level that is held for whole cycles. The stimulus meets this by driving all inputs on the falling edge only. Short-circuit bursts last one to eight cycles, so some stay below the qualification length and some exceed it. Under-voltage windows are held for tens of cycles, so both short and long windows relative to the fault pulse occur.

// File: rtl/invgate_pkg.sv
package invgate_pkg;

  // Width of a counter that must hold values 0..n.
  function automatic int unsigned cnt_w(input int unsigned n);
    int unsigned w;
    w = $clog2(n + 1);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/invgate_sync.sv
module invgate_sync #(
  parameter int unsigned W       = 1,
  parameter bit          RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= {W{RST_ONE}};
      dout   <= {W{RST_ONE}};
    end else begin
      meta_q <= din;
      dout   <= meta_q;
    end
  end

endmodule

// File: rtl/invgate_fault.sv
module invgate_fault #(
  parameter int unsigned SC_QUAL   = 220,
  parameter int unsigned FAULT_CYC = 225000
) (
  input  logic clk,
  input  logic rst,
  input  logic sc_s,
  input  logic uv_lo_s,
  output logic lo_block,
  output logic fault_n
);
  import invgate_pkg::*;

  localparam int unsigned QW = cnt_w(SC_QUAL);
  localparam int unsigned FW = cnt_w(FAULT_CYC);

  logic [QW-1:0] qual_cnt;
  logic [FW-1:0] pulse_cnt;
  logic          uv_prev;
  logic          sc_trip;
  logic          uv_rise;
  logic          start_req;
  logic          pulse_last;

  // The trip fires once per assertion episode: the counter saturates after it.
  assign sc_trip    = sc_s && (qual_cnt == QW'(SC_QUAL - 1));
  assign uv_rise    = uv_lo_s && !uv_prev;
  assign start_req  = sc_trip || uv_rise;
  assign pulse_last = (pulse_cnt == FW'(FAULT_CYC - 1));

  // Lower legs are blocked from the trip edge onward, and for as long as UV lasts.
  assign lo_block   = !fault_n || uv_lo_s || sc_trip;

  always_ff @(posedge clk) begin
    if (rst) begin
      qual_cnt <= '0;
    end else if (!sc_s) begin
      qual_cnt <= '0;
    end else if (qual_cnt != QW'(SC_QUAL)) begin
      qual_cnt <= qual_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_prev   <= 1'b0;
      fault_n   <= 1'b1;
      pulse_cnt <= '0;
    end else begin
      uv_prev <= uv_lo_s;
      if (!fault_n) begin
        if (pulse_last) begin
          fault_n   <= 1'b1;
          pulse_cnt <= '0;
        end else begin
          pulse_cnt <= pulse_cnt + 1'b1;
        end
      end else if (start_req) begin
        fault_n   <= 1'b0;
        pulse_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/invgate_phase.sv
module invgate_phase #(
  parameter int unsigned DEAD_CYC = 375
) (
  input  logic clk,
  input  logic rst,
  input  logic hon,
  input  logic lon,
  input  logic uv_hi_s,
  input  logic lo_block,
  output logic gate_hi,
  output logic gate_lo
);
  import invgate_pkg::*;

  localparam int unsigned DW = cnt_w(DEAD_CYC);

  logic [DW-1:0] dt_cnt;
  logic          armed;
  logic          hon_prev;
  logic          fresh_on;
  logic          allow_hi;
  logic          want_hi;
  logic          want_lo;
  logic          both_req;
  logic          dt_done;
  logic          hi_nxt;
  logic          lo_nxt;
  logic          turn_off;

  always_comb begin
    fresh_on = hon && !hon_prev;
    allow_hi = !uv_hi_s && (armed || fresh_on);
    want_hi  = hon && allow_hi;
    want_lo  = lon && !lo_block;
    both_req = hon && lon;
    dt_done  = (dt_cnt == '0);
    hi_nxt   = want_hi && !both_req && (gate_hi || (!gate_lo && dt_done));
    lo_nxt   = want_lo && !both_req && (gate_lo || (!gate_hi && dt_done));
    turn_off = (gate_hi && !hi_nxt) || (gate_lo && !lo_nxt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi  <= 1'b0;
      gate_lo  <= 1'b0;
      armed    <= 1'b0;
      hon_prev <= 1'b0;
      dt_cnt   <= '0;
    end else begin
      gate_hi  <= hi_nxt;
      gate_lo  <= lo_nxt;
      hon_prev <= hon;
      if (uv_hi_s) begin
        armed <= 1'b0;
      end else if (fresh_on) begin
        armed <= 1'b1;
      end
      if (turn_off) begin
        dt_cnt <= DW'(DEAD_CYC);
      end else if (!dt_done) begin
        dt_cnt <= dt_cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/invgate_guard.sv
module invgate_guard #(
  parameter int unsigned NPH       = 3,
  parameter int unsigned SC_QUAL   = 220,
  parameter int unsigned FAULT_CYC = 225000,
  parameter int unsigned DEAD_CYC  = 375
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] cmd_hi_n,
  input  logic [NPH-1:0] cmd_lo_n,
  input  logic           sc_flag,
  input  logic           uv_lo_flag,
  input  logic [NPH-1:0] uv_hi_flag,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo,
  output logic           fault_n
);

  localparam int unsigned FLW = NPH + 2;

  logic [NPH-1:0] hi_n_s;
  logic [NPH-1:0] lo_n_s;
  logic [FLW-1:0] flags_s;
  logic           lo_block;

  invgate_sync #(.W(NPH), .RST_ONE(1'b1)) i_sync_hi (
    .clk(clk), .rst(rst), .din(cmd_hi_n), .dout(hi_n_s)
  );

  invgate_sync #(.W(NPH), .RST_ONE(1'b1)) i_sync_lo (
    .clk(clk), .rst(rst), .din(cmd_lo_n), .dout(lo_n_s)
  );

  invgate_sync #(.W(FLW), .RST_ONE(1'b0)) i_sync_flags (
    .clk(clk), .rst(rst), .din({uv_hi_flag, uv_lo_flag, sc_flag}), .dout(flags_s)
  );

  invgate_fault #(.SC_QUAL(SC_QUAL), .FAULT_CYC(FAULT_CYC)) i_fault (
    .clk      (clk),
    .rst      (rst),
    .sc_s     (flags_s[0]),
    .uv_lo_s  (flags_s[1]),
    .lo_block (lo_block),
    .fault_n  (fault_n)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    invgate_phase #(.DEAD_CYC(DEAD_CYC)) i_phase (
      .clk      (clk),
      .rst      (rst),
      .hon      (!hi_n_s[p]),
      .lon      (!lo_n_s[p]),
      .uv_hi_s  (flags_s[2+p]),
      .lo_block (lo_block),
      .gate_hi  (gate_hi[p]),
      .gate_lo  (gate_lo[p])
    );
  end

endmodule

// File: rtl/invgate_guard_chk.sv
module invgate_guard_chk #(
  parameter int unsigned NPH       = 3,
  parameter int unsigned FAULT_CYC = 225000,
  parameter int unsigned DEAD_CYC  = 375
) (
  input logic           clk,
  input logic           rst,
  input logic [NPH-1:0] gate_hi,
  input logic [NPH-1:0] gate_lo,
  input logic           fault_n
);
  import invgate_pkg::*;

  localparam int unsigned AW = cnt_w(DEAD_CYC);
  localparam int unsigned LW = cnt_w(FAULT_CYC);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt <= '0;
    end else if (!fault_n) begin
      if (low_cnt != LW'(FAULT_CYC)) low_cnt <= low_cnt + 1'b1;
    end else begin
      low_cnt <= '0;
    end
  end

  // R7: the pulse ends after exactly FAULT_CYC low cycles
  a_r7_pulse_width: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_n) |-> (low_cnt == LW'(FAULT_CYC)));

  // R8: no pulse ever runs longer than FAULT_CYC cycles
  a_r8_no_extend: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> (low_cnt < LW'(FAULT_CYC)));

  // R9: lower legs are off whenever the fault output is active
  a_r9_lo_blocked: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> (gate_lo == '0));

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic          prev_h;
    logic          prev_l;
    logic [AW-1:0] off_age;

    always_ff @(posedge clk) begin
      if (rst) begin
        prev_h  <= 1'b0;
        prev_l  <= 1'b0;
        off_age <= AW'(DEAD_CYC);
      end else begin
        prev_h <= gate_hi[p];
        prev_l <= gate_lo[p];
        if ((prev_h && !gate_hi[p]) || (prev_l && !gate_lo[p])) begin
          off_age <= '0;
        end else if (off_age != AW'(DEAD_CYC)) begin
          off_age <= off_age + 1'b1;
        end
      end
    end

    // R4: the two legs of one phase never conduct together
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
      !(gate_hi[p] && gate_lo[p]));

    // R4: an upper turn-on respects the dead gap
    a_r4_gap_hi: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_hi[p]) |-> (off_age >= AW'(DEAD_CYC)));

    // R4: a lower turn-on respects the dead gap
    a_r4_gap_lo: assert property (@(posedge clk) disable iff (rst)
      $rose(gate_lo[p]) |-> (off_age >= AW'(DEAD_CYC)));
  end

endmodule

bind invgate_guard invgate_guard_chk #(
  .NPH(NPH), .FAULT_CYC(FAULT_CYC), .DEAD_CYC(DEAD_CYC)
) i_guard_chk (
  .clk(clk), .rst(rst), .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
);

// File: tb/test_invgate_guard.sv
module test_invgate_guard;
  localparam int NPH = 3;
  localparam int SCQ = 4;
  localparam int FCY = 30;
  localparam int DCY = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NPH-1:0] cmd_hi_n   = '1;
  logic [NPH-1:0] cmd_lo_n   = '1;
  logic [NPH-1:0] uv_hi_flag = '0;
  logic           sc_flag    = 1'b0;
  logic           uv_lo_flag = 1'b0;
  logic [NPH-1:0] gate_hi;
  logic [NPH-1:0] gate_lo;
  logic           fault_n;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  invgate_guard #(.NPH(NPH), .SC_QUAL(SCQ), .FAULT_CYC(FCY), .DEAD_CYC(DCY)) i_invgate_guard (
    .clk(clk), .rst(rst), .cmd_hi_n(cmd_hi_n), .cmd_lo_n(cmd_lo_n),
    .sc_flag(sc_flag), .uv_lo_flag(uv_lo_flag), .uv_hi_flag(uv_hi_flag),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // Reference model of the requirements, cycle by cycle
  logic [NPH-1:0] m_ch1, m_ch2, m_cl1, m_cl2, m_uh1, m_uh2, m_arm, m_hp, m_gh, m_gl;
  logic [NPH-1:0] t_nh, t_nl;
  logic           m_sc1, m_sc2, m_uv1, m_uv2, m_uvp, m_fa;
  logic           t_trip, t_uvr, t_start, t_blk;
  int             m_scc, m_fc;
  int             m_dt [NPH];
  int             t_dt [NPH];

  function automatic logic leg_next(input logic want, input logic both, input logic self_on,
                                    input logic other_on, input int gap);
    return want && !both && (self_on || (!other_on && gap == 0));
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ch1 = '1; m_ch2 = '1; m_cl1 = '1; m_cl2 = '1;
      m_uh1 = '0; m_uh2 = '0; m_arm = '0; m_hp = '0; m_gh = '0; m_gl = '0;
      m_sc1 = 0; m_sc2 = 0; m_uv1 = 0; m_uv2 = 0; m_uvp = 0; m_fa = 0;
      m_scc = 0; m_fc = 0;
      for (int p = 0; p < NPH; p++) m_dt[p] = 0;
    end else begin
      t_trip  = m_sc2 && (m_scc == SCQ - 1);
      t_uvr   = m_uv2 && !m_uvp;
      t_start = t_trip || t_uvr;
      t_blk   = m_fa || m_uv2 || t_trip;
      for (int p = 0; p < NPH; p++) begin
        logic hon, lon, fresh, wh, wl, both;
        hon   = !m_ch2[p];
        lon   = !m_cl2[p];
        fresh = hon && !m_hp[p];
        wh    = hon && !m_uh2[p] && (m_arm[p] || fresh);
        wl    = lon && !t_blk;
        both  = hon && lon;
        t_nh[p] = leg_next(wh, both, m_gh[p], m_gl[p], m_dt[p]);
        t_nl[p] = leg_next(wl, both, m_gl[p], m_gh[p], m_dt[p]);
        if ((m_gh[p] && !t_nh[p]) || (m_gl[p] && !t_nl[p])) t_dt[p] = DCY;
        else if (m_dt[p] > 0) t_dt[p] = m_dt[p] - 1;
        else t_dt[p] = 0;
        if (m_uh2[p]) m_arm[p] = 1'b0;
        else if (fresh) m_arm[p] = 1'b1;
        m_hp[p] = hon;
      end
      if (m_fa) begin
        if (m_fc == FCY - 1) begin m_fa = 0; m_fc = 0; end
        else m_fc++;
      end else if (t_start) begin
        m_fa = 1; m_fc = 0;
      end
      if (!m_sc2) m_scc = 0;
      else if (m_scc != SCQ) m_scc++;
      m_uvp = m_uv2;
      m_gh = t_nh; m_gl = t_nl;
      for (int p = 0; p < NPH; p++) m_dt[p] = t_dt[p];
      m_ch2 = m_ch1; m_ch1 = cmd_hi_n;
      m_cl2 = m_cl1; m_cl1 = cmd_lo_n;
      m_uh2 = m_uh1; m_uh1 = uv_hi_flag;
      m_sc2 = m_sc1; m_sc1 = sc_flag;
      m_uv2 = m_uv1; m_uv1 = uv_lo_flag;
    end
  end

  // R2 gates and R7 fault output compared with the model every cycle
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 gate_hi vs model", int'(gate_hi), int'(m_gh));
      chk("R2 gate_lo vs model", int'(gate_lo), int'(m_gl));
      chk("R7 fault_n vs model", int'(fault_n), int'(!m_fa));
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int n;
    void'($urandom(32'd90210));
    step(4);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 gate_hi", int'(gate_hi), 0);
    chk("R1 gate_lo", int'(gate_lo), 0);
    chk("R1 fault_n", int'(fault_n), 1);

    // R2 polarity and latency
    cmd_hi_n[0] = 1'b0;
    step(2);
    chk("R2 not yet", int'(gate_hi[0]), 0);
    step(1);
    chk("R2 latency", int'(gate_hi[0]), 1);

    // R4 dead gap on a hand-over
    cmd_hi_n[0] = 1'b1;
    cmd_lo_n[0] = 1'b0;
    n = 0;
    while (gate_hi[0] && n < 20) begin step(1); n++; end
    n = 0;
    while (!gate_lo[0] && n < 40) begin step(1); n++; end
    chk("R4 dead gap", n, DCY + 1);

    // R3 both legs requested
    cmd_hi_n[1] = 1'b0;
    cmd_lo_n[1] = 1'b0;
    step(10);
    chk("R3 both off hi", int'(gate_hi[1]), 0);
    chk("R3 both off lo", int'(gate_lo[1]), 0);
    cmd_lo_n[1] = 1'b1;
    step(10);
    chk("R3 release", int'(gate_hi[1]), 1);

    // R5 short burst ignored
    cmd_lo_n[2] = 1'b0;
    step(10);
    chk("R5 lo on", int'(gate_lo[2]), 1);
    sc_flag = 1'b1;
    step(SCQ - 1);
    sc_flag = 1'b0;
    for (int i = 0; i < 10; i++) begin
      step(1);
      chk("R5 fault idle", int'(fault_n), 1);
      chk("R5 lo kept", int'(gate_lo[2]), 1);
    end

    // R6..R9 qualified trip
    sc_flag = 1'b1;
    n = 0;
    while (fault_n && n < 20) begin step(1); n++; end
    chk("R6 low legs off", int'(gate_lo), 0);
    chk("R6 high leg kept", int'(gate_hi[1]), 1);
    n = 0;
    while (!fault_n && n < 200) begin
      chk("R9 low held off", int'(gate_lo), 0);
      if (n == 3) sc_flag = 1'b0;
      if (n == 10) sc_flag = 1'b1;
      if (n == 16) sc_flag = 1'b0;
      step(1);
      n++;
    end
    chk("R7 pulse width", n, FCY);
    chk("R8 no retrigger", n, FCY);
    step(5);
    chk("R9 resume", int'(gate_lo[0]), 1);

    // R10 lower-side under-voltage
    uv_lo_flag = 1'b1;
    n = 0;
    while (fault_n && n < 20) begin step(1); n++; end
    chk("R10 fault starts", int'(fault_n), 0);
    step(FCY + 10);
    chk("R10 pulse over", int'(fault_n), 1);
    chk("R10 low off while flag", int'(gate_lo), 0);
    uv_lo_flag = 1'b0;
    step(6);
    chk("R10 resume", int'(gate_lo[0]), 1);

    // R11 / R12 upper-side under-voltage and re-arm
    uv_hi_flag[1] = 1'b1;
    step(5);
    chk("R11 hi off", int'(gate_hi[1]), 0);
    for (int i = 0; i < 10; i++) begin
      step(1);
      chk("R11 no fault", int'(fault_n), 1);
    end
    uv_hi_flag[1] = 1'b0;
    step(10);
    chk("R12 stays off", int'(gate_hi[1]), 0);
    cmd_hi_n[1] = 1'b1;
    step(3);
    cmd_hi_n[1] = 1'b0;
    step(10);
    chk("R12 fresh on", int'(gate_hi[1]), 1);

    // Random stimulus, checked by the model
    begin
      int sc_left, uvl_left;
      int uvh_left [NPH];
      sc_left = 0; uvl_left = 0;
      for (int p = 0; p < NPH; p++) uvh_left[p] = 0;
      for (int c = 0; c < 4000; c++) begin
        if ($urandom_range(0, 19) == 0) begin
          int b;
          b = $urandom_range(0, 2 * NPH - 1);
          if (b < NPH) cmd_hi_n[b] = ~cmd_hi_n[b];
          else cmd_lo_n[b - NPH] = ~cmd_lo_n[b - NPH];
        end
        if (sc_left > 0) sc_left--;
        else if ($urandom_range(0, 149) == 0) sc_left = $urandom_range(1, 8);
        sc_flag = (sc_left > 0);
        if (uvl_left > 0) uvl_left--;
        else if ($urandom_range(0, 399) == 0) uvl_left = $urandom_range(20, 60);
        uv_lo_flag = (uvl_left > 0);
        for (int p = 0; p < NPH; p++) begin
          if (uvh_left[p] > 0) uvh_left[p]--;
          else if ($urandom_range(0, 499) == 0) uvh_left[p] = $urandom_range(5, 40);
          uv_hi_flag[p] = (uvh_left[p] > 0);
        end
        step(1);
      end
    end

    cmd_hi_n = '1; cmd_lo_n = '1; sc_flag = 1'b0; uv_lo_flag = 1'b0; uv_hi_flag = '0;
    step(10);
    chk("R2 all off at end hi", int'(gate_hi), 0);
    chk("R2 all off at end lo", int'(gate_lo), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule